// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block picks which of 256 numbered interrupt vectors the processor services next and decides when a routine that is already running may be cut short. Vector 0 is the most urgent and vector 255 the least. A request is held in a pending bit until it is taken. A per-vector mask keeps a request from being taken while it is set. A running routine is pre-empted only by an unmasked request of strictly higher priority.

When the controller takes a vector, it raises a one-cycle strobe. With the strobe it presents the vector number and the word address of that vector's two-word entry slot at the bottom of memory. The processor fetches from that slot.

Each taken vector is recorded as in service. The current level is the most urgent in-service vector. An end-of-service pulse retires that vector and so restores the level that was active before it. Three sources set pending bits:
- an internal divider raises vector 0 once per period (1 ms at the default setting);
- an instruction-driven raise port sets any vector from 1 to 255;
- a peripheral request bus sets vectors 16 to 255.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no vector is pending or in service, `take` is low and `svc_valid` is low.
- R2: The lowest-numbered vector that is pending and unmasked is selected. A request sampled at one clock edge produces `take` high at the following edge, with `take_vec` equal to that vector.
- R3: A pending vector whose `mask_i` bit is 1 is never taken. It stays pending and is taken once its mask bit returns to 0.
- R4: While a vector is in service, only a pending unmasked vector with a strictly lower number is taken. When it is taken, `svc_lvl` becomes that vector in the same cycle that `take` is high.
- R5: `take_addr` equals `take_vec` times 2, zero-extended to 20 bits. Vector 0x37 gives 0x0006E and vector 0xFF gives 0x001FE.
- R6: An `eos` pulse clears the in-service bit of the current level. `svc_lvl` then shows the next in-service vector, or `svc_valid` goes low if none is left.
- R7: Vector 0 is made pending once every `TICK_DIV` clock cycles by the internal divider.
- R8: A `sw_raise` pulse makes vector `sw_vec` pending for any value 1 to 255. A value of 0 is ignored.
- R9: `hw_req` bits 0 to 15 have no effect. Only bits 16 to 255 set pending vectors.
- R10: `take` is high for one cycle per taken request, and taking a vector clears its pending bit, so a single request is serviced once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 256 | Peripheral request pulses, one bit per vector (bits 0-15 ignored) |
| sw_raise | input | 1 | Instruction-driven raise strobe |
| sw_vec | input | 8 | Vector to raise with `sw_raise` |
| mask_i | input | 256 | Mask, 1 blocks the vector |
| eos | input | 1 | End of service for the current level |
| take | output | 1 | One-cycle strobe: a vector is taken |
| take_vec | output | 8 | Number of the taken vector |
| take_addr | output | 20 | Word address of the vector's entry slot |
| svc_valid | output | 1 | At least one vector is in service |
| svc_lvl | output | 8 | Most urgent in-service vector |

## Verification
Several vectors are raised in the same cycle. If the priority order were inverted, or the encoder returned the highest set bit, the order of service would come out reversed.

A nesting sequence first checks that a request of lower priority than the running routine is held back. It then checks that this request is taken as soon as end of service uncovers it. A design that compared the wrong way, or that retired the oldest rather than the most urgent in-service bit, would pre-empt too early or restore the wrong level.

Further checks cover:
- masked requests;
- a raise of vector 0 through the software port;
- peripheral requests on the reserved low vectors;
- the exact spacing between timer ticks.

A wrong divider count, a software port that accepted vector 0, or reserved bits leaking through would each cause an unexpected take or a wrong interval.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_NUM_VEC  = 256;
  localparam int IRQ_VEC_W    = 8;
  localparam int IRQ_ADDR_W   = 20;
  localparam int IRQ_HW_FIRST = 16;
  localparam int IRQ_TICK_DIV = 50000;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int N = 256,
  parameter int W = 8
) (
  input  logic [N-1:0] bits,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R7: a tick is a single-cycle event when the period exceeds one cycle
  p_tick_single_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && DIV > 1) |=> !tick);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_VEC  = IRQ_NUM_VEC,
  parameter int VEC_W    = IRQ_VEC_W,
  parameter int ADDR_W   = IRQ_ADDR_W,
  parameter int HW_FIRST = IRQ_HW_FIRST,
  parameter int TICK_DIV = IRQ_TICK_DIV
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] hw_req,
  input  logic               sw_raise,
  input  logic [VEC_W-1:0]   sw_vec,
  input  logic [NUM_VEC-1:0] mask_i,
  input  logic               eos,
  output logic               take,
  output logic [VEC_W-1:0]   take_vec,
  output logic [ADDR_W-1:0]  take_addr,
  output logic               svc_valid,
  output logic [VEC_W-1:0]   svc_lvl
);
  localparam logic [NUM_VEC-1:0] ONE     = NUM_VEC'(1);
  localparam logic [NUM_VEC-1:0] HW_KEEP = ~((ONE << HW_FIRST) - ONE);

  logic [NUM_VEC-1:0] pend_q, insvc_q, mask_q;
  logic [NUM_VEC-1:0] set_v, take_clr, eos_clr, cand;
  logic               tick, c_found, go;
  logic [VEC_W-1:0]   c_idx;

  irq_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  always_comb begin
    set_v = hw_req & HW_KEEP;
    if (tick) set_v[0] = 1'b1;
    if (sw_raise && sw_vec != '0) set_v = set_v | (ONE << sw_vec);
  end

  assign cand = pend_q & ~mask_i;

  irq_first_set #(.N(NUM_VEC), .W(VEC_W)) u_cand (
    .bits  (cand),
    .found (c_found),
    .idx   (c_idx)
  );

  irq_first_set #(.N(NUM_VEC), .W(VEC_W)) u_lvl (
    .bits  (insvc_q),
    .found (svc_valid),
    .idx   (svc_lvl)
  );

  assign go       = c_found && (!svc_valid || c_idx < svc_lvl);
  assign take_clr = go ? (ONE << c_idx) : '0;
  assign eos_clr  = (eos && svc_valid) ? (ONE << svc_lvl) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      insvc_q   <= '0;
      mask_q    <= '0;
      take      <= 1'b0;
      take_vec  <= '0;
      take_addr <= '0;
    end else begin
      pend_q  <= (pend_q & ~take_clr) | set_v;
      insvc_q <= (insvc_q & ~eos_clr) | take_clr;
      mask_q  <= mask_i;
      take    <= go;
      if (go) begin
        take_vec  <= c_idx;
        take_addr <= ADDR_W'(c_idx) << 1;
      end
    end
  end

  // R3: a taken vector was unmasked when it was chosen
  p_unmasked_take_r3: assert property (@(posedge clk) disable iff (rst)
    take |-> !mask_q[take_vec]);

  // R4: the taken vector is the current level while take is high
  p_take_level_r4: assert property (@(posedge clk) disable iff (rst)
    take |-> (svc_valid && svc_lvl == take_vec));

  // R4: pre-emption only by a strictly more urgent vector
  p_preempt_r4: assert property (@(posedge clk) disable iff (rst)
    (take && $past(svc_valid)) |-> take_vec < $past(svc_lvl));

  // R5: entry slot address is twice the vector number
  p_slot_addr_r5: assert property (@(posedge clk) disable iff (rst)
    take |-> (take_addr[0] == 1'b0 && (take_addr >> 1) == ADDR_W'(take_vec)));

  // R6: end of service retires the current level
  p_eos_retire_r6: assert property (@(posedge clk) disable iff (rst)
    (eos && svc_valid) |=> (take || !svc_valid || svc_lvl > $past(svc_lvl)));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int NV  = 256;
  localparam int DIV = 40;

  logic          clk = 1'b0;
  logic          rst;
  logic [NV-1:0] hw_req;
  logic          sw_raise;
  logic [7:0]    sw_vec;
  logic [NV-1:0] mask_i;
  logic          eos;
  logic          take;
  logic [7:0]    take_vec;
  logic [19:0]   take_addr;
  logic          svc_valid;
  logic [7:0]    svc_lvl;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .hw_req(hw_req), .sw_raise(sw_raise), .sw_vec(sw_vec),
    .mask_i(mask_i), .eos(eos), .take(take), .take_vec(take_vec),
    .take_addr(take_addr), .svc_valid(svc_valid), .svc_lvl(svc_lvl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw_pulse(input int v);
    @(negedge clk); hw_req[v] = 1'b1;
    @(negedge clk); hw_req = '0;
  endtask

  task automatic eos_pulse();
    @(negedge clk); eos = 1'b1;
    @(negedge clk); eos = 1'b0;
  endtask

  task automatic wait_take(input int lim, output bit got, output logic [7:0] v);
    got = 1'b0; v = '0;
    for (int i = 0; i < lim; i++) begin
      if (take) begin got = 1'b1; v = take_vec; break; end
      @(negedge clk);
    end
  endtask

  task automatic expect_take(input string req, input logic [7:0] exp);
    bit got; logic [7:0] v;
    wait_take(60, got, v);
    chk(req, {31'd0, got}, 32'd1);
    chk(req, {24'd0, v}, {24'd0, exp});
  endtask

  task automatic expect_quiet(input string req, input int cyc);
    bit got; logic [7:0] v;
    wait_take(cyc, got, v);
    chk(req, {31'd0, got}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 take", {31'd0, take}, 32'd0);
    chk("R1 svc_valid", {31'd0, svc_valid}, 32'd0);
  endtask

  task automatic t_single();
    @(negedge clk); hw_req[8'h37] = 1'b1;
    @(negedge clk); hw_req = '0;
    chk("R2 no take yet", {31'd0, take}, 32'd0);
    @(negedge clk);
    chk("R2 take timing", {31'd0, take}, 32'd1);
    chk("R2 vector", {24'd0, take_vec}, 32'h37);
    chk("R5 slot addr", {12'd0, take_addr}, 32'h6E);
    chk("R4 level", {24'd0, svc_lvl}, 32'h37);
    @(negedge clk);
    chk("R10 single cycle", {31'd0, take}, 32'd0);
    eos_pulse();
    chk("R6 level gone", {31'd0, svc_valid}, 32'd0);
    expect_quiet("R10 no re-take", 8);
  endtask

  task automatic t_order();
    @(negedge clk); hw_req[8'h80] = 1'b1; hw_req[8'h20] = 1'b1; hw_req[8'h50] = 1'b1;
    @(negedge clk); hw_req = '0;
    expect_take("R2 first", 8'h20);
    @(negedge clk);
    expect_quiet("R4 lower held", 8);
    eos_pulse();
    expect_take("R2 second", 8'h50);
    eos_pulse();
    expect_take("R2 third", 8'h80);
    eos_pulse();
    chk("R6 empty", {31'd0, svc_valid}, 32'd0);
  endtask

  task automatic t_mask();
    mask_i[8'h40] = 1'b1;
    hw_pulse(8'h40);
    expect_quiet("R3 masked", 10);
    mask_i[8'h40] = 1'b0;
    expect_take("R3 unmasked", 8'h40);
    eos_pulse();
  endtask

  task automatic t_nest();
    hw_pulse(8'h90);
    expect_take("R4 base", 8'h90);
    hw_pulse(8'h30);
    expect_take("R4 preempt", 8'h30);
    chk("R4 level 30", {24'd0, svc_lvl}, 32'h30);
    hw_pulse(8'h60);
    expect_quiet("R4 no preempt", 10);
    @(negedge clk); eos = 1'b1;
    @(negedge clk); eos = 1'b0;
    chk("R6 restored 90", {24'd0, svc_lvl}, 32'h90);
    expect_take("R6 uncovered", 8'h60);
    eos_pulse();
    chk("R6 back to 90", {24'd0, svc_lvl}, 32'h90);
    eos_pulse();
    chk("R6 empty", {31'd0, svc_valid}, 32'd0);
  endtask

  task automatic t_sw();
    @(negedge clk); sw_raise = 1'b1; sw_vec = 8'hFF;
    @(negedge clk); sw_raise = 1'b0;
    expect_take("R8 sw FF", 8'hFF);
    chk("R5 addr FF", {12'd0, take_addr}, 32'h1FE);
    eos_pulse();
  endtask

  task automatic t_hw_low();
    hw_pulse(5);
    hw_pulse(15);
    expect_quiet("R9 reserved ignored", 10);
  endtask

  task automatic t_tick();
    int gap;
    mask_i[0] = 1'b0;
    expect_take("R7 tick a", 8'h00);
    eos_pulse();
    expect_take("R7 tick b", 8'h00);
    gap = 0;
    @(negedge clk); eos = 1'b1; gap++;
    @(negedge clk); eos = 1'b0; gap++;
    sw_raise = 1'b1; sw_vec = 8'h00;
    @(negedge clk); sw_raise = 1'b0; gap++;
    for (int i = 0; i < 3 * DIV && !take; i++) begin
      @(negedge clk); gap++;
    end
    chk("R7 period", gap, DIV);
    chk("R8 sw 0 ignored (no early take)", {31'd0, take}, 32'd1);
    mask_i[0] = 1'b1;
    eos_pulse();
  endtask

  initial begin
    rst = 1'b1; hw_req = '0; sw_raise = 1'b0; sw_vec = '0; eos = 1'b0;
    mask_i = '0; mask_i[0] = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_mask();
    t_nest();
    t_sw();
    t_hw_low();
    t_tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule